// File: doc/BRIEF.md
# Multi-Mode Serial Shift Register

This block is an 8-bit shift register that moves data between a parallel CPU-side port and a two-wire serial link: a shift clock pin and a serial data pin. A 3-bit mode input selects one of eight behaviours. Shifting goes either into the register, from the data pin, or out of it, onto the data pin. The shift clock comes from one of three sources: an internal divider reloaded from a rate value N, the system clock, or pulses that an external device applies to the clock pin. When the block itself produces the shift clock, it drives the clock pin.

A bit counter tracks each group of eight shifts. Some modes stop after eight bits, some keep shifting and only raise the flag, one recirculates the byte endlessly, and one disables the counter altogether. The flag, gated by an enable input, produces an active-low interrupt. A CPU read or write of the register restarts the group and clears the flag. In the divider modes, that access starts the first clock transition at once if the flag was set; otherwise the first transition waits for the divider's next natural time-out.

Top module: `shreg_multimode`

## Requirements
- R1: After reset the register reads 0, the flag and the data output are 0, the clock output is 1, irq_n is 1, the mode is 0 and both pin enables are 0.
- R2: A write strobe loads wdata into the register on that clock edge. rdata always shows the current register contents.
- R3: In mode 0 the flag is held at 0, and each synchronized rising edge of sclk_i shifts the synchronized sdat_i level into bit 0.
- R4: sclk_i and sdat_i each pass through SYNC_STAGES flip-flops. A rising sclk_i level first sampled at edge k shifts the register at edge k+SYNC_STAGES, using the sdat_i level sampled at edge k. Two shifts never come from consecutive cycles.
- R5: In modes 1, 4 and 5 a divider counts down from rate_n and reloads when it reaches 0, so it times out every rate_n+1 cycles. While the mode is running, each time-out toggles sclk_o. The toggle from 0 to 1 is a shift event.
- R6: In modes 1 and 5 a CPU access made while the flag is 1 forces a divider time-out on the next cycle. When the flag is 0, the divider is left alone and the first toggle comes at its natural time-out.
- R7: Modes 1, 2, 5 and 6 stop after 8 shift events. The flag is then set, sclk_o rests at 1, and sdat_o keeps the last bit sent.
- R8: In modes 2 and 6, sclk_o toggles on every cycle while running, which gives one shift event every two cycles. The divider has no influence on these modes.
- R9: Modes 3 and 7 shift on each external edge and never stop. The flag sets on every eighth event. A CPU access clears the flag and restarts the count. A read in the same cycle as an event keeps that event as the first of the new group.
- R10: Mode 4 rotates the register at the divider rate without stopping, and the flag is held at 0.
- R11: In modes 4 to 7 each shift event copies bit 7 into the sdat_o register and rotates the register left, so bit 7 moves to bit 0. In modes 0 to 3 the register moves left and the input bit enters bit 0.
- R12: A write wins over a shift event in the same cycle, and that event is dropped. In modes 1, 2, 5 and 6 any access restarts the sequence with sclk_o at 1 and drops that cycle's event.
- R13: irq_n is low exactly when the flag is 1 and irq_en is 1. sclk_oe is 1 in modes 1, 2, 4, 5 and 6. sdat_oe is 1 in modes 4 to 7.
- R14: A new mode value takes effect on the next clock edge. That edge cancels any running sequence, sets sclk_o to 1 and clears the bit count, and leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Behaviour select, 0 to 7 |
| rate_n | input | DIV_W | Divider reload value N |
| irq_en | input | 1 | Interrupt enable |
| sr_wr | input | 1 | CPU write strobe |
| sr_rd | input | 1 | CPU read strobe |
| wdata | input | DW | CPU write data |
| rdata | output | DW | Register contents |
| sclk_i | input | 1 | Clock pin input level |
| sclk_o | output | 1 | Clock pin driven level |
| sclk_oe | output | 1 | Clock pin drive enable |
| sdat_i | input | 1 | Data pin input level |
| sdat_o | output | 1 | Data pin driven level |
| sdat_oe | output | 1 | Data pin drive enable |
| done | output | 1 | Shift-complete flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A CPU access can land in the same cycle as a shift event. This matters most for an external clock edge, which arrives a fixed synchronizer delay after the pin rises. The bench raises sclk_i and then times the write or read strobe so that the strobe is sampled on the very edge where the synchronized rise becomes a shift. Two cases are judged: a write in mode 0 must leave exactly the written byte, and a read in mode 7 must keep the shift and count it as the first bit of a fresh group. A reference model compares every output on every cycle; it also covers an access arriving in a divider or system-rate mode in the cycle the clock toggles.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

   typedef enum logic [2:0] {
      SHM_OFF      = 3'd0,
      SHM_IN_TMR   = 3'd1,
      SHM_IN_SYS   = 3'd2,
      SHM_IN_EXT   = 3'd3,
      SHM_OUT_LOOP = 3'd4,
      SHM_OUT_TMR  = 3'd5,
      SHM_OUT_SYS  = 3'd6,
      SHM_OUT_EXT  = 3'd7
   } shm_e;

   // divider paced modes that stop after one byte
   function automatic logic shm_tmr_stop(input shm_e m);
      return (m == SHM_IN_TMR) || (m == SHM_OUT_TMR);
   endfunction

   function automatic logic shm_sys(input shm_e m);
      return (m == SHM_IN_SYS) || (m == SHM_OUT_SYS);
   endfunction

   function automatic logic shm_stops(input shm_e m);
      return shm_tmr_stop(m) || shm_sys(m);
   endfunction

   function automatic logic shm_counts(input shm_e m);
      return (m == SHM_IN_EXT) || (m == SHM_OUT_EXT);
   endfunction

   function automatic logic shm_drives_clk(input shm_e m);
      return shm_stops(m) || (m == SHM_OUT_LOOP);
   endfunction

   function automatic logic shm_is_out(input shm_e m);
      return m[2];
   endfunction

endpackage

// File: rtl/shreg_sync_edge.sv
module shreg_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_clk,
   input  logic pin_dat,
   output logic rise,
   output logic dat
);

   logic [STAGES-1:0] ck_s;
   logic [STAGES-1:0] dt_s;
   logic              ck_last;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("shreg_sync_edge: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ck_s <= '0;
               dt_s <= '0;
            end else begin
               ck_s <= pin_clk;
               dt_s <= pin_dat;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ck_s <= '0;
               dt_s <= '0;
            end else begin
               ck_s <= {ck_s[STAGES-2:0], pin_clk};
               dt_s <= {dt_s[STAGES-2:0], pin_dat};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ck_last <= 1'b0;
      else        ck_last <= ck_s[STAGES-1];
   end

   assign rise = ck_s[STAGES-1] & ~ck_last;
   assign dat  = dt_s[STAGES-1];

   AST_EDGE_SPACED: assert property (@(posedge clk) disable iff (!rst_n) rise |=> !rise); // R4

endmodule

// File: rtl/shreg_rate_div.sv
module shreg_rate_div #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic [W-1:0] reload,
   output logic         tick
);

   logic [W-1:0] cnt_q;

   generate
      if (W < 1) begin : g_bad_w
         $error("shreg_rate_div: W must be at least 1");
      end
   endgenerate

   assign tick = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (tick)    cnt_q <= reload;
      else              cnt_q <= cnt_q - 1'b1;
   end

   AST_DIV_RELOAD:  assert property (@(posedge clk) disable iff (!rst_n) (tick && !restart) |=> (cnt_q == $past(reload))); // R5
   AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n) restart |=> tick); // R6

endmodule

// File: rtl/shreg_bit_cnt.sv
module shreg_bit_cnt #(
   parameter int LIMIT = 8,
   parameter int W     = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic wrap
);

   localparam logic [W-1:0] LAST = W'(LIMIT - 1);

   logic [W-1:0] count_q;

   generate
      if (LIMIT < 2 || (1 << W) < LIMIT) begin : g_bad_limit
         $error("shreg_bit_cnt: LIMIT out of range for W");
      end
   endgenerate

   assign wrap = step & ~clear & (count_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count_q <= '0;
      else if (clear) count_q <= step ? W'(1) : '0;
      else if (step)  count_q <= wrap ? '0 : count_q + 1'b1;
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (count_q <= LAST)); // R9

endmodule

// File: rtl/shreg_multimode.sv
module shreg_multimode
   import shreg_pkg::*;
#(
   parameter int DW          = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       mode,
   input  logic [DIV_W-1:0] rate_n,
   input  logic             irq_en,
   input  logic             sr_wr,
   input  logic             sr_rd,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   input  logic             sclk_i,
   output logic             sclk_o,
   output logic             sclk_oe,
   input  logic             sdat_i,
   output logic             sdat_o,
   output logic             sdat_oe,
   output logic             done,
   output logic             irq_n
);

   localparam int CNT_W = $clog2(DW + 1);

   generate
      if (DW < 2) begin : g_bad_dw
         $error("shreg_multimode: DW must be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("shreg_multimode: SYNC_STAGES must be at least 1");
      end
   endgenerate

   shm_e          mode_in, mode_q;
   logic          mode_chg, acc;
   logic [DW-1:0] sr_q, sr_shift;
   logic          flag_q, run_q, sclk_q, dout_q;
   logic          ext_rise, ext_dat, tick, div_restart;
   logic          ev, tog, take, stop_m, cnt_m, out_m;
   logic          cnt_clr, cnt_step, cnt_wrap;

   assign mode_in  = shm_e'(mode);
   assign mode_chg = (mode_in != mode_q);
   assign acc      = sr_wr | sr_rd;
   assign stop_m   = shm_stops(mode_q);
   assign cnt_m    = shm_counts(mode_q);
   assign out_m    = shm_is_out(mode_q);

   shreg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_clk (sclk_i),
      .pin_dat (sdat_i),
      .rise    (ext_rise),
      .dat     (ext_dat)
   );

   assign div_restart = acc & flag_q & shm_tmr_stop(mode_q) & ~mode_chg;

   shreg_rate_div #(.W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (div_restart),
      .reload  (rate_n),
      .tick    (tick)
   );

   // shift event source per mode
   always_comb begin
      ev  = 1'b0;
      tog = 1'b0;
      if (shm_tmr_stop(mode_q)) begin
         ev  = run_q & tick & ~sclk_q;
         tog = run_q & tick;
      end else if (mode_q == SHM_OUT_LOOP) begin
         ev  = tick & ~sclk_q;
         tog = tick;
      end else if (shm_sys(mode_q)) begin
         ev  = run_q & ~sclk_q;
         tog = run_q;
      end else begin
         ev  = ext_rise;
      end
   end

   assign take = ev & ~sr_wr & ~mode_chg & ~(acc & stop_m);

   always_comb begin
      if (out_m) sr_shift = {sr_q[DW-2:0], sr_q[DW-1]};
      else       sr_shift = {sr_q[DW-2:0], ext_dat};
   end

   assign cnt_clr  = mode_chg | (acc & (stop_m | cnt_m));
   assign cnt_step = take & (stop_m | cnt_m);

   shreg_bit_cnt #(.LIMIT(DW), .W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (cnt_clr),
      .step  (cnt_step),
      .wrap  (cnt_wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= SHM_OFF;
         sr_q   <= '0;
         dout_q <= 1'b0;
      end else begin
         mode_q <= mode_in;
         if (sr_wr)     sr_q <= wdata;
         else if (take) sr_q <= sr_shift;
         if (take && out_m) dout_q <= sr_q[DW-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         run_q  <= 1'b0;
         sclk_q <= 1'b1;
      end else if (mode_chg) begin
         run_q  <= 1'b0;
         sclk_q <= 1'b1;
      end else if (stop_m) begin
         if (acc) begin
            run_q  <= 1'b1;
            sclk_q <= 1'b1;
            flag_q <= 1'b0;
         end else begin
            if (tog) sclk_q <= ~sclk_q;
            if (cnt_wrap) begin
               run_q  <= 1'b0;
               flag_q <= 1'b1;
            end
         end
      end else if (mode_q == SHM_OUT_LOOP) begin
         flag_q <= 1'b0;
         if (tog) sclk_q <= ~sclk_q;
      end else if (cnt_m) begin
         if (acc)           flag_q <= 1'b0;
         else if (cnt_wrap) flag_q <= 1'b1;
      end else begin
         flag_q <= 1'b0;
      end
   end

   assign rdata   = sr_q;
   assign sclk_o  = sclk_q;
   assign sclk_oe = shm_drives_clk(mode_q);
   assign sdat_o  = dout_q;
   assign sdat_oe = out_m;
   assign done    = flag_q;
   assign irq_n   = ~(flag_q & irq_en);

   AST_OFF_NO_FLAG:    assert property (@(posedge clk) disable iff (!rst_n) (mode_q == SHM_OFF && !mode_chg) |=> !flag_q); // R3
   AST_LOOP_KEEPS:     assert property (@(posedge clk) disable iff (!rst_n) (mode_q == SHM_OUT_LOOP && !mode_chg && !sr_wr) |=> ($countones(sr_q) == $countones($past(sr_q)))); // R10
   AST_WR_LOADS:       assert property (@(posedge clk) disable iff (!rst_n) sr_wr |=> (sr_q == $past(wdata))); // R12
   AST_ACC_CLEARS:     assert property (@(posedge clk) disable iff (!rst_n) (acc && !mode_chg && (stop_m || cnt_m)) |=> !flag_q); // R9
   AST_IDLE_HIGH:      assert property (@(posedge clk) disable iff (!rst_n) (stop_m && !run_q) |-> sclk_q); // R7
   AST_MODE_CANCELS:   assert property (@(posedge clk) disable iff (!rst_n) mode_chg |=> (sclk_q && !run_q)); // R14

endmodule

// File: tb/test_shreg_multimode.sv
`timescale 1ns/1ps
module test_shreg_multimode;

   localparam int DW = 8;
   localparam int DIV_W = 8;
   localparam int SS = 2;

   logic             clk = 1'b0;
   logic             rst_n;
   logic [2:0]       mode;
   logic [DIV_W-1:0] rate_n;
   logic             irq_en, sr_wr, sr_rd, sclk_i, sdat_i;
   logic [DW-1:0]    wdata, rdata;
   logic             sclk_o, sclk_oe, sdat_o, sdat_oe, done, irq_n;

   always #2 clk = ~clk;

   shreg_multimode #(.DW(DW), .DIV_W(DIV_W), .SYNC_STAGES(SS)) i_shreg_multimode (
      .clk(clk), .rst_n(rst_n), .mode(mode), .rate_n(rate_n), .irq_en(irq_en),
      .sr_wr(sr_wr), .sr_rd(sr_rd), .wdata(wdata), .rdata(rdata),
      .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
      .sdat_i(sdat_i), .sdat_o(sdat_o), .sdat_oe(sdat_oe),
      .done(done), .irq_n(irq_n)
   );

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";

   // behavioural reference model state
   int m_mode, m_sr, m_flag, m_run, m_sclk, m_dout, m_div, m_cnt;
   int ckh [0:SS+1];
   int dth [0:SS+1];

   always @(posedge clk) begin : model
      int rise, din, tick, acc, chg, stopm, cntm, outm, ev, tog, take, wrap;
      if (!rst_n) begin
         m_mode = 0; m_sr = 0; m_flag = 0; m_run = 0; m_sclk = 1; m_dout = 0; m_div = 0; m_cnt = 0;
         for (int i = 0; i <= SS+1; i++) begin ckh[i] = 0; dth[i] = 0; end
      end else begin
         for (int i = SS+1; i > 0; i--) begin ckh[i] = ckh[i-1]; dth[i] = dth[i-1]; end
         ckh[0] = sclk_i; dth[0] = sdat_i;
         rise  = (ckh[SS] == 1 && ckh[SS+1] == 0);
         din   = dth[SS];
         tick  = (m_div == 0);
         acc   = sr_wr || sr_rd;
         chg   = (int'(mode) != m_mode);
         stopm = (m_mode == 1 || m_mode == 2 || m_mode == 5 || m_mode == 6);
         cntm  = (m_mode == 3 || m_mode == 7);
         outm  = (m_mode >= 4);
         case (m_mode)
            1, 5:    begin ev = m_run && tick && !m_sclk; tog = m_run && tick; end
            4:       begin ev = tick && !m_sclk; tog = tick; end
            2, 6:    begin ev = m_run && !m_sclk; tog = m_run; end
            default: begin ev = rise; tog = 0; end
         endcase
         take = ev && !sr_wr && !chg && !(acc && stopm);
         if (acc && m_flag && (m_mode == 1 || m_mode == 5) && !chg) m_div = 0;
         else if (tick) m_div = rate_n;
         else m_div = m_div - 1;
         wrap = 0;
         if (chg || (acc && (stopm || cntm))) m_cnt = (take && (stopm || cntm)) ? 1 : 0;
         else if (take && (stopm || cntm)) begin
            if (m_cnt == DW-1) begin wrap = 1; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
         end
         if (take && outm) m_dout = (m_sr >> (DW-1)) & 1;
         if (sr_wr) m_sr = wdata;
         else if (take) m_sr = ((m_sr << 1) | (outm ? ((m_sr >> (DW-1)) & 1) : din)) & ((1 << DW) - 1);
         if (chg) begin m_run = 0; m_sclk = 1; end
         else if (stopm) begin
            if (acc) begin m_run = 1; m_sclk = 1; m_flag = 0; end
            else begin
               if (tog) m_sclk = !m_sclk;
               if (wrap) begin m_run = 0; m_flag = 1; end
            end
         end else if (m_mode == 4) begin
            m_flag = 0;
            if (tog) m_sclk = !m_sclk;
         end else if (cntm) begin
            if (acc) m_flag = 0;
            else if (wrap) m_flag = 1;
         end else m_flag = 0;
         m_mode = mode;
      end
   end

   // cycle compare, sampled at the falling edge before inputs move
   always @(negedge clk) begin
      int e_oe_c, e_irq;
      if (rst_n) begin
         e_oe_c = (m_mode == 1 || m_mode == 2 || m_mode == 4 || m_mode == 5 || m_mode == 6);
         e_irq  = !(m_flag && irq_en);
         checks++;
         if (int'(rdata) != m_sr || int'(sclk_o) != m_sclk || int'(sclk_oe) != e_oe_c ||
             int'(sdat_o) != m_dout || int'(sdat_oe) != (m_mode >= 4) || int'(done) != m_flag ||
             int'(irq_n) != e_irq) begin
            errors++;
            $display("FAIL %s model t=%0t: rdata %h/%h sclk %b/%0d oe %b/%0d sdat %b/%0d sdoe %b/%0d done %b/%0d irq_n %b/%0d",
                     cur_req, $time, rdata, m_sr[7:0], sclk_o, m_sclk, sclk_oe, e_oe_c, sdat_o, m_dout,
                     sdat_oe, (m_mode >= 4), done, m_flag, irq_n, e_irq);
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic cpu_wr(input logic [DW-1:0] v);
      sr_wr = 1'b1; wdata = v; step(1); sr_wr = 1'b0;
   endtask

   task automatic cpu_rd();
      sr_rd = 1'b1; step(1); sr_rd = 1'b0;
   endtask

   task automatic set_mode(input logic [2:0] m);
      mode = m; step(2);
   endtask

   task automatic ext_pulse(input logic d);
      sdat_i = d; sclk_i = 1'b1; step(3); sclk_i = 1'b0; step(3);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      rst_n = 1'b0; mode = 3'd0; rate_n = 8'd3; irq_en = 1'b1;
      sr_wr = 1'b0; sr_rd = 1'b0; wdata = '0; sclk_i = 1'b0; sdat_i = 1'b0;
      step(3); rst_n = 1'b1; step(1);

      cur_req = "R1";
      chk("R1", "rdata", rdata, 0);
      chk("R1", "sclk_o", sclk_o, 1);
      chk("R1", "irq_n", irq_n, 1);
      chk("R1", "done", done, 0);
      chk("R1", "oe", {sclk_oe, sdat_oe}, 0);

      cur_req = "R2";
      cpu_wr(8'h3C);
      chk("R2", "write load", rdata, 'h3C);

      cur_req = "R3";
      ext_pulse(1'b1); ext_pulse(1'b0); ext_pulse(1'b1);
      chk("R3", "mode0 shift in", rdata, 'hE5);
      chk("R3", "mode0 flag", done, 0);

      cur_req = "R4";
      sdat_i = 1'b0; sclk_i = 1'b1;
      step(2);
      chk("R4", "no shift before sync", rdata, 'hE5);
      step(1);
      chk("R4", "shift after sync", rdata, 'hCA);
      sclk_i = 1'b0; step(3);

      cur_req = "R12";
      sdat_i = 1'b1; sclk_i = 1'b1; step(2);
      cpu_wr(8'h11);
      chk("R12", "write beats ext shift", rdata, 'h11);
      sclk_i = 1'b0; step(4);

      cur_req = "R8";
      sdat_i = 1'b1;
      set_mode(3'd2);
      cpu_wr(8'h00);
      step(20);
      chk("R8", "sys rate shift in", rdata, 'hFF);
      chk("R7", "stop flag", done, 1);
      chk("R7", "clock idle", sclk_o, 1);

      cur_req = "R13";
      chk("R13", "irq asserted", irq_n, 0);
      irq_en = 1'b0; step(1);
      chk("R13", "irq masked", irq_n, 1);
      irq_en = 1'b1;

      cur_req = "R11";
      set_mode(3'd6);
      chk("R13", "data oe", sdat_oe, 1);
      cpu_wr(8'h96);
      step(20);
      chk("R11", "rotate restores", rdata, 'h96);
      chk("R7", "data holds last bit", sdat_o, 0);
      chk("R7", "done after 8", done, 1);

      cur_req = "R6";
      set_mode(3'd5);
      cpu_wr(8'hC3);
      step(1);
      chk("R6", "immediate toggle", sclk_o, 0);
      cur_req = "R5";
      step(70);
      chk("R5", "timer out done", done, 1);
      chk("R5", "timer out data", rdata, 'hC3);
      chk("R7", "hold last level", sdat_o, 1);

      cur_req = "R6";
      sdat_i = 1'b0; rate_n = 8'd1;
      set_mode(3'd1);
      cpu_rd();
      cpu_wr(8'h5A);
      step(50);
      chk("R6", "timer in result", rdata, 'h00);
      chk("R6", "timer in done", done, 1);

      cur_req = "R9";
      set_mode(3'd3);
      cpu_rd();
      chk("R9", "flag cleared", done, 0);
      for (int i = 0; i < 8; i++) ext_pulse((i % 2) == 0);
      chk("R9", "ext in byte", rdata, 'hAA);
      chk("R9", "ext in flag", done, 1);
      ext_pulse(1'b1);
      chk("R9", "keeps shifting", rdata, 'h55);
      cpu_rd();
      chk("R9", "read clears", done, 0);

      set_mode(3'd7);
      cpu_wr(8'hF0);
      sclk_i = 1'b1; step(2);
      cpu_rd();
      chk("R9", "read keeps event", rdata, 'hE1);
      sclk_i = 1'b0; step(4);
      for (int i = 0; i < 7; i++) ext_pulse(1'b0);
      chk("R9", "count includes read event", done, 1);
      chk("R11", "ext out rotate", rdata, 'hF0);

      cur_req = "R10";
      rate_n = 8'd2;
      set_mode(3'd4);
      cpu_wr(8'h81);
      step(60);
      chk("R10", "loop flag", done, 0);
      chk("R10", "loop ones", $countones(rdata), 2);

      cur_req = "R14";
      set_mode(3'd2);
      cpu_wr(8'h00);
      step(3);
      mode = 3'd0; step(2);
      chk("R14", "clock back high", sclk_o, 1);
      chk("R14", "clock oe off", sclk_oe, 0);
      step(4);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule